// File: doc/BRIEF.md
# Operand Forwarding Unit

This block steers the two ALU operands of the execute stage in a five-stage in-order pipeline. It compares the two source register numbers of the instruction now in execute against the destination numbers of the two older instructions still in flight: one in the memory stage and one in writeback. For each operand it produces a 2-bit select. The select routes in the register file value, the memory-stage result or the writeback result, so a result reaches the instruction that depends on it before it has been written back. Because of this, dependent ALU instructions can issue on consecutive cycles with no stall.

The block is purely combinational. Its outputs follow its inputs in the same cycle, and it holds no state. Each operand is decided on its own, so both operands may forward in the same cycle and may take their values from different stages. The two operand multiplexers sit inside the block, and their width is a parameter.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage qualifies as a producer for a source, that operand's select is 2'b00 and the operand output equals the register file value for that operand.
- R2: The memory stage qualifies for a source when its write flag is 1, its destination is nonzero and its destination equals that source. When it qualifies, the select is 2'b10 and the operand equals the memory-stage result.
- R3: When the writeback stage qualifies (write flag 1, nonzero destination equal to the source) and the memory stage does not, the select is 2'b01 and the operand equals the writeback result.
- R4: Register 0 is never forwarded. A destination of 0 never qualifies, so a source of 0 always gives select 2'b00.
- R5: A stage whose write flag is 0 never qualifies, whatever its destination number.
- R6: When both stages qualify for the same source, including three chained writes to one register, the memory stage wins and the select is 2'b10.
- R7: A memory stage whose destination matches but that does not qualify (write flag 0 or destination 0) does not block a qualifying writeback stage. The select is then 2'b01.
- R8: Operand A is decided from the first source field and operand B from the second, each on its own. Both may forward in one cycle, from the same stage or from different stages.
- R9: The select code 2'b11 never appears on either select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register number of the instruction in execute |
| ex_src_b | input | REG_W | Second source register number of the instruction in execute |
| mem_dst | input | REG_W | Destination register number held by the memory stage |
| mem_wr | input | 1 | Register-write flag of the memory stage |
| wb_dst | input | REG_W | Destination register number held by the writeback stage |
| wb_wr | input | 1 | Register-write flag of the writeback stage |
| rf_data_a | input | DATA_W | Register file value read for operand A |
| rf_data_b | input | DATA_W | Register file value read for operand B |
| mem_result | input | DATA_W | Result held in the memory stage |
| wb_result | input | DATA_W | Result held in the writeback stage |
| sel_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 memory |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | DATA_W | Value delivered to ALU operand A |
| opnd_b | output | DATA_W | Value delivered to ALU operand B |

## Verification
The block holds no state, so a faulty comparison or a faulty priority shows at the select and operand ports in the same cycle the inputs are applied. Every stimulus is therefore checked after the inputs settle within that cycle. A priority fault shows only when both stages name the same register, a qualification fault only when a non-qualifying stage matches, and a register-zero fault only when a destination of 0 is presented. For that reason the bench sweeps every combination of a small set of register numbers and both write flags, in addition to its directed vectors.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Priority pick: the younger producer (memory stage) wins.
  function automatic logic [1:0] fwd_pick(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return FWD_MEM;
    else if (wb_hit) return FWD_WB;
    else             return FWD_RF;
  endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A stage is a producer only if it writes a real (nonzero) register
  // and that register is the one the source asks for.
  function automatic logic producer_hit(input logic we,
                                        input logic [REG_W-1:0] d,
                                        input logic [REG_W-1:0] s);
    return we && (d != ZERO_REG) && (d == s);
  endfunction

  assign hit = producer_hit(wr_en, dst, src);

endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  logic       mem_hit,
  input  logic       wb_hit,
  output logic [1:0] sel
);

  assign sel = fwd_pick(mem_hit, wb_hit);

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] out
);

  always_comb begin
    case (sel)
      FWD_MEM: out = mem_val;
      FWD_WB:  out = wb_val;
      default: out = rf_val;
    endcase
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_src_a,
  input  logic [REG_W-1:0]  ex_src_b,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wr,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wr,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [DATA_W-1:0] wb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int NUM_OPS = 2;

  // Per-operand views; index 0 is operand A, index 1 is operand B.
  logic [REG_W-1:0]  src_v  [NUM_OPS];
  logic [DATA_W-1:0] rf_v   [NUM_OPS];
  logic [1:0]        sel_v  [NUM_OPS];
  logic [DATA_W-1:0] opnd_v [NUM_OPS];

  // Named internal events, observed by the bound checker.
  logic [NUM_OPS-1:0] mem_hit;
  logic [NUM_OPS-1:0] wb_hit;

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rf_v[0]  = rf_data_a;
  assign rf_v[1]  = rf_data_b;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    fwd_match #(.REG_W(REG_W)) u_mem_match (
      .wr_en (mem_wr),
      .dst   (mem_dst),
      .src   (src_v[op]),
      .hit   (mem_hit[op])
    );

    fwd_match #(.REG_W(REG_W)) u_wb_match (
      .wr_en (wb_wr),
      .dst   (wb_dst),
      .src   (src_v[op]),
      .hit   (wb_hit[op])
    );

    fwd_select u_sel (
      .mem_hit (mem_hit[op]),
      .wb_hit  (wb_hit[op]),
      .sel     (sel_v[op])
    );

    fwd_opmux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel_v[op]),
      .rf_val  (rf_v[op]),
      .mem_val (mem_result),
      .wb_val  (wb_result),
      .out     (opnd_v[op])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  ex_src_a,
  input logic [REG_W-1:0]  ex_src_b,
  input logic [REG_W-1:0]  mem_dst,
  input logic              mem_wr,
  input logic [REG_W-1:0]  wb_dst,
  input logic              wb_wr,
  input logic [DATA_W-1:0] rf_data_a,
  input logic [DATA_W-1:0] mem_result,
  input logic [DATA_W-1:0] wb_result,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [1:0]        mem_hit,
  input logic [1:0]        wb_hit
);

  always_comb begin
    AST_A_MEM_QUAL: assert (sel_a != 2'b10 || (mem_wr && mem_dst != '0 && mem_dst == ex_src_a)); // R2
    AST_B_MEM_QUAL: assert (sel_b != 2'b10 || (mem_wr && mem_dst != '0 && mem_dst == ex_src_b)); // R8
    AST_A_WB_QUAL:  assert (sel_a != 2'b01 || (wb_wr && wb_dst != '0 && wb_dst == ex_src_a)); // R3
    AST_ZERO_SRC:   assert (ex_src_a != '0 || (sel_a == 2'b00 && mem_hit[0] == 1'b0)); // R4
    AST_IDLE_STAGES: assert ((mem_wr || wb_wr) || (sel_a == 2'b00 && sel_b == 2'b00)); // R5
    AST_MEM_FIRST:  assert (!(mem_hit[0] && wb_hit[0]) || opnd_a == mem_result); // R6
    AST_WB_ONLY:    assert (!(wb_hit[0] && !mem_hit[0]) || opnd_a == wb_result); // R7
    AST_NO_SOURCE:  assert ((mem_hit[0] || wb_hit[0]) || opnd_a == rf_data_a); // R1
    AST_NO_BAD_CODE: assert (sel_a != 2'b11 && sel_b != 2'b11); // R9
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .ex_src_a   (ex_src_a),
  .ex_src_b   (ex_src_b),
  .mem_dst    (mem_dst),
  .mem_wr     (mem_wr),
  .wb_dst     (wb_dst),
  .wb_wr      (wb_wr),
  .rf_data_a  (rf_data_a),
  .mem_result (mem_result),
  .wb_result  (wb_result),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .opnd_a     (opnd_a),
  .mem_hit    (mem_hit),
  .wb_hit     (wb_hit)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int NVEC   = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [REG_W-1:0]  ex_src_a, ex_src_b, mem_dst, wb_dst;
  logic              mem_wr, wb_wr;
  logic [DATA_W-1:0] rf_data_a, rf_data_b, mem_result, wb_result;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) uut (
    .ex_src_a, .ex_src_b, .mem_dst, .mem_wr, .wb_dst, .wb_wr,
    .rf_data_a, .rf_data_b, .mem_result, .wb_result,
    .sel_a, .sel_b, .opnd_a, .opnd_b
  );

  // Vector layout: src_a, src_b, mem_dst, mem_wr, wb_dst, wb_wr, exp_sel_a, exp_sel_b
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R1 no match
    {5'd1,  5'd2,  5'd1,  1'b1, 5'd4,  1'b1, 2'b10, 2'b00}, // R2 mem to A
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd2,  1'b1, 2'b00, 2'b01}, // R3 wb to B
    {5'd1,  5'd2,  5'd1,  1'b1, 5'd2,  1'b1, 2'b10, 2'b01}, // R8 both, different stages
    {5'd1,  5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 2'b10, 2'b10}, // R6 chained writes
    {5'd5,  5'd6,  5'd5,  1'b0, 5'd5,  1'b1, 2'b01, 2'b00}, // R7 mem not writing
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R4 register zero
    {5'd7,  5'd7,  5'd7,  1'b0, 5'd7,  1'b0, 2'b00, 2'b00}, // R5 no writes
    {5'd3,  5'd0,  5'd0,  1'b1, 5'd3,  1'b1, 2'b01, 2'b00}, // R7 mem dst zero
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd30, 1'b1, 2'b10, 2'b10}, // R2 top register
    {5'd9,  5'd8,  5'd8,  1'b1, 5'd9,  1'b1, 2'b01, 2'b10}  // R8 crossed stages
  };

  // Reference: later assignment overrides, so the memory stage wins.
  function automatic logic [1:0] ref_sel(input logic [REG_W-1:0] s,
                                         input logic [REG_W-1:0] md, input logic mw,
                                         input logic [REG_W-1:0] wd, input logic ww);
    logic [1:0] r = 2'b00;
    if (s != 0 && ww && wd == s) r = 2'b01;
    if (s != 0 && mw && md == s) r = 2'b10;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] ref_val(input logic [1:0] s, input logic [DATA_W-1:0] rf);
    return (s == 2'b10) ? mem_result : (s == 2'b01) ? wb_result : rf;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                       input logic [REG_W-1:0] md, input logic mw,
                       input logic [REG_W-1:0] wd, input logic ww);
    @(negedge clk);
    ex_src_a = sa; ex_src_b = sb; mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rf_data_a = 32'hAAAA_0001; rf_data_b = 32'hBBBB_0002;
    mem_result = 32'hCCCC_0003; wb_result = 32'hDDDD_0004;

    // Idle state: all zero inputs, nothing forwarded (R1, R4)
    drive('0, '0, '0, 1'b0, '0, 1'b0);
    check("R1 idle sel_a", {30'd0, sel_a}, 32'd0);
    check("R1 idle opnd_b", opnd_b, rf_data_b);

    // Directed table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][25:21], VEC[i][20:16], VEC[i][15:11], VEC[i][10], VEC[i][9:5], VEC[i][4]);
      check($sformatf("R8 vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
      check($sformatf("R8 vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
      check($sformatf("R9 vec%0d opnd_a", i), opnd_a, ref_val(VEC[i][3:2], rf_data_a));
      check($sformatf("R9 vec%0d opnd_b", i), opnd_b, ref_val(VEC[i][1:0], rf_data_b));
    end

    // Sweep of small register numbers and both write flags (R2..R7)
    for (int sa = 0; sa < 3; sa++)
      for (int md = 0; md < 3; md++)
        for (int wd = 0; wd < 3; wd++)
          for (int fl = 0; fl < 4; fl++) begin
            logic [REG_W-1:0] sb;
            logic [1:0] ea, eb;
            sb = REG_W'((sa + 1) % 3);
            drive(REG_W'(sa), sb, REG_W'(md), fl[0], REG_W'(wd), fl[1]);
            ea = ref_sel(REG_W'(sa), REG_W'(md), fl[0], REG_W'(wd), fl[1]);
            eb = ref_sel(sb, REG_W'(md), fl[0], REG_W'(wd), fl[1]);
            check("R6 sweep sel_a", {30'd0, sel_a}, {30'd0, ea});
            check("R7 sweep sel_b", {30'd0, sel_b}, {30'd0, eb});
            check("R2 sweep opnd_a", opnd_a, ref_val(ea, rf_data_a));
            check("R3 sweep opnd_b", opnd_b, ref_val(eb, rf_data_b));
          end

    // Data change with selects held: operand follows the chosen source (R9)
    drive(5'd4, 5'd6, 5'd4, 1'b1, 5'd6, 1'b1);
    mem_result = 32'h1234_5678; wb_result = 32'h8765_4321; #1;
    check("R9 follow mem", opnd_a, 32'h1234_5678);
    check("R9 follow wb", opnd_b, 32'h8765_4321);

    // Register zero destination with write set never forwards (R4)
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    check("R4 zero opnd_a", opnd_a, rf_data_a);
    // Write flag clear ignored even on exact match (R5)
    drive(5'd12, 5'd12, 5'd12, 1'b0, 5'd12, 1'b0);
    check("R5 noflag opnd_b", opnd_b, rf_data_b);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule